// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the 8-bit software-visible control and status register that sequences self-timed operations on an on-chip flash array. Software writes mode bits that choose between a row erase, a 2-byte write and a 64-byte block write, sets a write enable, and then sets a start bit. The block captures the operation type and the table-pointer address. It sends the array a one-cycle start strobe and waits for the array's done level. It then clears the start bit, and the erase mode bit when the operation was an erase.

The start bit cannot be cleared by software. An attempt to start without the write enable is rejected and recorded in an error flag. A warm reset that arrives while an operation is in flight aborts it and also sets the error flag. That flag survives the warm reset so that software can read why the operation did not finish. Only a power-on reset clears everything.

Top module: `flash_prog_ctl`

## Requirements
- R1: Bits 7, 6 and 0 of the register always read 0, and writes to them have no effect.
- R2: Power-on reset (`por_n` low) clears every register bit, including the error flag at bit 3, and holds `arr_start` low.
- R3: While no operation is in flight, a write loads bit 5 (1 = 2-byte write size, 0 = 64-byte), bit 4 (row erase select) and bit 2 (write enable), and each reads back at the same position.
- R4: A write with bit 1 = 1 and bit 2 = 1 while idle sets the start bit and raises `arr_start` for exactly one cycle, starting on the clock edge that accepts the write. On that edge it also captures `tblptr` on `arr_addr`.
- R5: The `arr_op` code captured at launch is 2'b01 when bit 4 is 1 (row erase, whatever bit 5 holds), 2'b10 for a 2-byte write (bit 4 = 0, bit 5 = 1) and 2'b11 for a 64-byte write (bits 4 and 5 = 0); it is 2'b00 after reset.
- R6: While the start bit is 1, register writes are ignored: writing 0 to bit 1 does not clear it, and the mode bits and the error flag keep their values.
- R7: When `arr_done` is sampled high while an operation is in flight and the strobe is low, the start bit clears on that same edge. Bit 4 is also cleared if it was set. The error flag stays 0. `arr_done` has no effect while idle.
- R8: A write with bit 1 = 1 and bit 2 = 0 while idle sets the error flag, leaves the start bit at 0 and produces no strobe.
- R9: A warm reset (`wrst_n` low) clears bits 5, 4, 2 and 1, as well as `arr_op` and `arr_addr`. It sets the error flag if an operation was in flight and otherwise leaves the flag unchanged.
- R10: Software can clear the error flag by writing 0 to bit 3 in a write with bit 1 = 0, but writing 1 cannot set it. A successful launch clears it.
- R11: `arr_op` and `arr_addr` stay stable for the whole operation, even when `tblptr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wrst_n | input | 1 | Synchronous warm reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| tblptr | input | ADDR_W | Table pointer address for the next operation |
| arr_start | output | 1 | One-cycle start strobe to the flash array |
| arr_op | output | 2 | Captured operation code |
| arr_addr | output | ADDR_W | Captured base address |
| arr_done | input | 1 | Array completion level |

## Verification
The hardest case to reach from the ports is a warm reset that lands while an operation is in flight. The error flag must then be set, and it must stay set through the same reset that clears every other bit. The bench reaches this case by launching an operation and holding `arr_done` low, which keeps the block busy for as long as needed. It then pulses `wrst_n` and reads the register back. It also checks the idle case, where the same reset must leave an existing flag untouched. Writes made during an operation are checked by reading the register back before `arr_done` is released.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_ERASE = 2'b01,
    OP_WR2   = 2'b10,
    OP_WR64  = 2'b11
  } fpc_op_e;

  typedef struct packed {
    logic size2;
    logic erase;
    logic err;
    logic wren;
    logic start;
  } fpc_ctrl_t;

  // Operation chosen by the mode bits; erase overrides the write size.
  function automatic fpc_op_e op_from_mode(logic erase, logic size2);
    if (erase) return OP_ERASE;
    return size2 ? OP_WR2 : OP_WR64;
  endfunction

  // Register image as software reads it; reserved bits forced low.
  function automatic logic [7:0] pack_ctrl(fpc_ctrl_t c);
    return {2'b00, c.size2, c.erase, c.err, c.wren, c.start, 1'b0};
  endfunction

endpackage

// File: rtl/fpc_wr_decode.sv
module fpc_wr_decode (
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       wrst_n,
  output logic       ev_mode_wr,
  output logic       ev_launch,
  output logic       ev_improper,
  output logic       ev_err_clr,
  output logic       ev_reserved,
  output logic       mode_size2,
  output logic       mode_erase,
  output logic       mode_wren
);
  logic live;

  // A write is acted upon only when idle and not held in warm reset.
  assign live        = we & wrst_n & ~busy;
  assign mode_size2  = wdata[5];
  assign mode_erase  = wdata[4];
  assign mode_wren   = wdata[2];
  assign ev_mode_wr  = live;
  assign ev_launch   = live & wdata[1] & wdata[2];
  assign ev_improper = live & wdata[1] & ~wdata[2];
  assign ev_err_clr  = live & ~wdata[1] & ~wdata[3];
  assign ev_reserved = we & (|{wdata[7:6], wdata[0]});

endmodule

// File: rtl/fpc_ctrl_reg.sv
module fpc_ctrl_reg
  import fpc_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      wrst_n,
  input  logic      ev_mode_wr,
  input  logic      ev_launch,
  input  logic      ev_improper,
  input  logic      ev_err_clr,
  input  logic      ev_done,
  input  logic      mode_size2,
  input  logic      mode_erase,
  input  logic      mode_wren,
  output fpc_ctrl_t ctrl
);
  fpc_ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= '0;
    end else if (!wrst_n) begin
      ctrl_q.size2 <= 1'b0;
      ctrl_q.erase <= 1'b0;
      ctrl_q.wren  <= 1'b0;
      ctrl_q.start <= 1'b0;
      ctrl_q.err   <= ctrl_q.err | ctrl_q.start;
    end else begin
      if (ev_done) begin
        ctrl_q.start <= 1'b0;
        ctrl_q.erase <= 1'b0;
      end
      if (ev_mode_wr) begin
        ctrl_q.size2 <= mode_size2;
        ctrl_q.erase <= mode_erase;
        ctrl_q.wren  <= mode_wren;
      end
      if (ev_launch) begin
        ctrl_q.start <= 1'b1;
        ctrl_q.err   <= 1'b0;
      end else if (ev_improper) begin
        ctrl_q.err   <= 1'b1;
      end else if (ev_err_clr) begin
        ctrl_q.err   <= 1'b0;
      end
    end
  end

  assign ctrl = ctrl_q;

  a_r8_improper_rejected: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    ev_improper |=> (!ctrl_q.start && ctrl_q.err));

  a_r9_warm_abort_flags: assert property (@(posedge clk) disable iff (!por_n)
    (!wrst_n && ctrl_q.start) |=> (ctrl_q.err && !ctrl_q.start));

  a_r9_warm_keeps_err: assert property (@(posedge clk) disable iff (!por_n)
    (!wrst_n && ctrl_q.err) |=> ctrl_q.err);

  a_r7_done_clears_start: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    ev_done |=> (!ctrl_q.start && !ctrl_q.erase && !ctrl_q.err));

  a_r6_busy_modes_frozen: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (ctrl_q.start && !ev_done) |=> (ctrl_q.start && $stable(ctrl_q.size2)
                                    && $stable(ctrl_q.erase) && $stable(ctrl_q.wren)));

endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              ev_launch,
  input  fpc_op_e           launch_op,
  input  logic [ADDR_W-1:0] tblptr,
  input  logic              arr_done,
  output logic              arr_start,
  output fpc_op_e           arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              busy,
  output logic              ev_done
);
  logic              busy_q;
  logic              strobe_q;
  fpc_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;

  // Done counts only after the strobe cycle, so a stale level cannot end it.
  assign ev_done = busy_q & ~strobe_q & arr_done;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      op_q     <= OP_NONE;
      addr_q   <= '0;
    end else if (!wrst_n) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      op_q     <= OP_NONE;
      addr_q   <= '0;
    end else begin
      strobe_q <= ev_launch;
      if (ev_launch) begin
        busy_q <= 1'b1;
        op_q   <= launch_op;
        addr_q <= tblptr;
      end else if (ev_done) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign arr_start = strobe_q;
  assign arr_op    = op_q;
  assign arr_addr  = addr_q;
  assign busy      = busy_q;

  a_r4_strobe_one_cycle: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    strobe_q |=> !strobe_q);

  a_r11_capture_held: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    (busy_q && !strobe_q) |-> ($stable(op_q) && $stable(addr_q)));

endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import fpc_pkg::*;
#(
  parameter int ADDR_W = 21
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] tblptr,
  output logic              arr_start,
  output logic [1:0]        arr_op,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_done
);
  logic      ev_mode_wr, ev_launch, ev_improper, ev_err_clr, ev_reserved;
  logic      mode_size2, mode_erase, mode_wren;
  logic      ev_done, seq_busy;
  fpc_ctrl_t ctrl;
  fpc_op_e   launch_op;
  fpc_op_e   op_out;

  assign launch_op = op_from_mode(mode_erase, mode_size2);

  fpc_wr_decode u_dec (
    .we          (reg_we),
    .wdata       (reg_wdata),
    .busy        (ctrl.start),
    .wrst_n      (wrst_n),
    .ev_mode_wr  (ev_mode_wr),
    .ev_launch   (ev_launch),
    .ev_improper (ev_improper),
    .ev_err_clr  (ev_err_clr),
    .ev_reserved (ev_reserved),
    .mode_size2  (mode_size2),
    .mode_erase  (mode_erase),
    .mode_wren   (mode_wren)
  );

  fpc_ctrl_reg u_reg (
    .clk         (clk),
    .por_n       (por_n),
    .wrst_n      (wrst_n),
    .ev_mode_wr  (ev_mode_wr),
    .ev_launch   (ev_launch),
    .ev_improper (ev_improper),
    .ev_err_clr  (ev_err_clr),
    .ev_done     (ev_done),
    .mode_size2  (mode_size2),
    .mode_erase  (mode_erase),
    .mode_wren   (mode_wren),
    .ctrl        (ctrl)
  );

  fpc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .wrst_n    (wrst_n),
    .ev_launch (ev_launch),
    .launch_op (launch_op),
    .tblptr    (tblptr),
    .arr_done  (arr_done),
    .arr_start (arr_start),
    .arr_op    (op_out),
    .arr_addr  (arr_addr),
    .busy      (seq_busy),
    .ev_done   (ev_done)
  );

  assign arr_op    = op_out;
  assign reg_rdata = pack_ctrl(ctrl);

  a_r4_launch_strobes: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    ev_launch |=> (arr_start && reg_rdata[1]));

  a_r7_busy_agrees: assert property (@(posedge clk) disable iff (!por_n)
    seq_busy == ctrl.start);

  a_r1_reserved_ignored: assert property (@(posedge clk) disable iff (!por_n)
    ev_reserved |=> (reg_rdata[7:6] == 2'b00 && reg_rdata[0] == 1'b0));

  a_r8_no_strobe_on_reject: assert property (@(posedge clk) disable iff (!por_n || !wrst_n)
    ev_improper |=> !arr_start);

endmodule

// File: tb/flash_prog_ctl_bench.sv
module flash_prog_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          wrst_n = 1'b1;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [AW-1:0] tblptr = '0;
  logic          arr_start;
  logic [1:0]    arr_op;
  logic [AW-1:0] arr_addr;
  logic          arr_done = 1'b0;

  int checks = 0;
  int failures = 0;

  flash_prog_ctl #(.ADDR_W(AW)) u_flash_prog_ctl (
    .clk(clk), .por_n(por_n), .wrst_n(wrst_n), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tblptr(tblptr),
    .arr_start(arr_start), .arr_op(arr_op), .arr_addr(arr_addr),
    .arr_done(arr_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] exp);
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_done();
    @(negedge clk); arr_done = 1'b1;
    @(negedge clk); arr_done = 1'b0;
  endtask

  task automatic warm_reset();
    @(negedge clk); wrst_n = 1'b0;
    @(negedge clk); wrst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk_reg("R2 reset value", 8'h00);
    check(arr_start === 1'b0, "R2 strobe low", arr_start, 0);
    check(arr_op === 2'b00, "R5 op after reset", arr_op, 0);
  endtask

  task automatic t_reserved();
    write_reg(8'hC1);
    chk_reg("R1 reserved bits", 8'h00);
    check(arr_start === 1'b0, "R1 no strobe", arr_start, 0);
  endtask

  task automatic t_modes();
    write_reg(8'h34); chk_reg("R3 modes set", 8'h34);
    write_reg(8'h24); chk_reg("R3 erase cleared", 8'h24);
    write_reg(8'h00); chk_reg("R3 all cleared", 8'h00);
  endtask

  task automatic t_write64();
    tblptr = 21'h01234;
    write_reg(8'h06);
    chk_reg("R4 start set", 8'h06);
    check(arr_start === 1'b1, "R4 strobe high", arr_start, 1);
    check(arr_op === 2'b11, "R5 op 64-byte", arr_op, 3);
    check(arr_addr === 21'h01234, "R4 address captured", arr_addr, 21'h01234);
    tblptr = 21'h1ABCD;
    @(negedge clk);
    check(arr_start === 1'b0, "R4 strobe one cycle", arr_start, 0);
    check(arr_addr === 21'h01234, "R11 address held", arr_addr, 21'h01234);
    write_reg(8'h00); chk_reg("R6 start not cleared", 8'h06);
    write_reg(8'h34); chk_reg("R6 modes frozen", 8'h06);
    check(arr_op === 2'b11, "R11 op held", arr_op, 3);
    pulse_done();
    chk_reg("R7 completion", 8'h04);
    pulse_done();
    chk_reg("R7 idle done ignored", 8'h04);
  endtask

  task automatic t_write2();
    write_reg(8'h26);
    check(arr_op === 2'b10, "R5 op 2-byte", arr_op, 2);
    pulse_done();
    chk_reg("R7 write2 complete", 8'h24);
  endtask

  task automatic t_erase();
    tblptr = 21'h00400;
    write_reg(8'h36);
    check(arr_op === 2'b01, "R5 op erase", arr_op, 1);
    check(arr_addr === 21'h00400, "R4 erase address", arr_addr, 21'h00400);
    pulse_done();
    chk_reg("R7 erase bit cleared", 8'h24);
  endtask

  task automatic t_improper();
    write_reg(8'h02);
    chk_reg("R8 improper sets err", 8'h08);
    check(arr_start === 1'b0, "R8 no strobe", arr_start, 0);
  endtask

  task automatic t_err_clear();
    write_reg(8'h08); chk_reg("R10 write 1 keeps err", 8'h08);
    write_reg(8'h00); chk_reg("R10 write 0 clears err", 8'h00);
    write_reg(8'h0C); chk_reg("R10 write 1 cannot set", 8'h04);
    write_reg(8'h02); chk_reg("R8 improper again", 8'h08);
    write_reg(8'h0E); chk_reg("R10 launch clears err", 8'h06);
    pulse_done();
    chk_reg("R7 done after relaunch", 8'h04);
  endtask

  task automatic t_warm_busy();
    write_reg(8'h26);
    repeat (3) @(negedge clk);
    chk_reg("R6 busy before warm reset", 8'h26);
    warm_reset();
    chk_reg("R9 warm abort sets err", 8'h08);
    check(arr_op === 2'b00, "R9 op cleared", arr_op, 0);
    check(arr_addr === '0, "R9 addr cleared", arr_addr, 0);
  endtask

  task automatic t_warm_idle();
    write_reg(8'h2C); chk_reg("R3 modes with err", 8'h2C);
    warm_reset();    chk_reg("R9 idle warm keeps err", 8'h08);
    write_reg(8'h00);
    warm_reset();    chk_reg("R9 idle warm no err", 8'h00);
    write_reg(8'h02);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    chk_reg("R2 power-on clears err", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reserved();
    t_modes();
    t_write64();
    t_write2();
    t_erase();
    t_improper();
    t_err_clear();
    t_warm_busy();
    t_warm_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule